// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a memory-mapped mailbox between a host processor and a system controller. The host writes a command word that launches a request. It reads a status word and fills a small write buffer with payload. It also reads back a response buffer. On the other side the controller gets a one-cycle doorbell and the latched command fields. It reads the payload by word index, writes the response buffer, and ends the request with a done strobe that carries an error flag, an error code and an initiator id.

The command word holds the request in one write. It carries an opcode in bits [7:0] and an interrupt-on-completion flag in bit 8. It also carries a sub-command id in [15:12] and a payload size in [23:16]. The size is passed on as given and does not depend on how many buffer writes came before it. Only the controller's done strobe ends the busy state and updates the error fields. When the completed request had asked for it, the host receives a single-cycle interrupt edge that it never has to clear.

Top module: `ipc_mailbox`

## Requirements
- R1: A host write to offset 0x00 while idle sets busy and pulses ctlDoorbell for exactly one cycle, both visible in the cycle after the write. From then on ctlCmd, ctlIoc, ctlSubId and ctlSize show write bits [7:0], [8], [15:12] and [23:16].
- R2: A read of offset 0x04 returns the status word. It holds busy in bit 0, error in bit 1, overrun in bit 2, the latched sub-command id in [7:4], the initiator id in [15:8] and the error code in [23:16]. Bit 3 and bits [31:24] read zero.
- R3: ctlDone while busy clears busy and captures ctlErr, ctlErrCode and ctlInitId into the status in the next cycle. ctlDone while idle changes nothing.
- R4: hostIrq is a one-cycle pulse in the cycle after an accepted ctlDone, only when the completed command had bit 8 set.
- R5: A command write while busy is ignored: no doorbell, and the latched fields are unchanged. It sets the overrun flag, which stays set until reset.
- R6: Host writes to offsets 0x80, 0x84, 0x88 and 0x8C fill write-buffer words 0 to 3. The controller reads word i on ctlWbufData, with no cycle delay, when ctlWbufIdx=i.
- R7: The controller writes response word i with ctlRbufWe. The host reads it at 0x90+4i. With hostByte=1 the read returns the byte selected by address bits [1:0], zero-extended, with byte 0 in bits [7:0].
- R8: Reads of the command offset and of the write buffer return zero. Host writes to the status offset or to the response buffer have no effect.
- R9: hostRdata is registered. It takes the read result in the cycle after hostRd and holds it until the next read.
- R10: After reset the status reads zero and hostIrq and ctlDoorbell are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | ADDR_W | Host byte address |
| hostWdata | input | 32 | Host write data |
| hostByte | input | 1 | Host read returns a single byte |
| hostRdata | output | 32 | Registered host read data |
| hostIrq | output | 1 | Completion interrupt pulse |
| ctlDoorbell | output | 1 | One-cycle new-request pulse |
| ctlCmd | output | 8 | Latched opcode |
| ctlIoc | output | 1 | Latched interrupt-on-completion flag |
| ctlSubId | output | 4 | Latched sub-command id |
| ctlSize | output | 8 | Latched payload size |
| ctlWbufIdx | input | IDX_W | Write-buffer word index |
| ctlWbufData | output | 32 | Write-buffer word at that index |
| ctlRbufWe | input | 1 | Response-buffer write enable |
| ctlRbufIdx | input | IDX_W | Response-buffer word index |
| ctlRbufData | input | 32 | Response-buffer write data |
| ctlDone | input | 1 | Completion strobe |
| ctlErr | input | 1 | Error flag sampled with ctlDone |
| ctlErrCode | input | 8 | Error code sampled with ctlDone |
| ctlInitId | input | 8 | Initiator id sampled with ctlDone |

## Verification
A host command write and the controller's done strobe can land on the same clock edge. The busy value at that edge decides the outcome, so the write is treated as an overrun even though busy drops in the next cycle. The bench makes this happen by driving both strobes in one cycle while a request is pending. It then checks four things: no doorbell, the overrun bit set, busy clear, and an interrupt only when the pending command had asked for one. Random rounds also place overrun writes between launch and completion, and the bench checks that the latched fields seen by the controller stay unchanged.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } mbState_t;

  typedef struct packed {
    logic latchCmd;
    logic setOverrun;
    logic captureDone;
  } mbStrobes_t;

endpackage

// File: rtl/ipc_mailbox_ctrl.sv
module ipc_mailbox_ctrl
  import ipc_mailbox_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWrite,
  input  logic       iocReq,
  input  logic       ctlDone,
  output logic       busy,
  output logic       doorbell,
  output logic       irqPulse,
  output logic       iocHeld,
  output mbStrobes_t strobes
);

  mbState_t state;

  always_comb begin
    strobes.latchCmd    = cmdWrite && (state == ST_IDLE);
    strobes.setOverrun  = cmdWrite && (state == ST_BUSY);
    strobes.captureDone = ctlDone && (state == ST_BUSY);
  end

  assign busy = (state == ST_BUSY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      doorbell <= 1'b0;
      irqPulse <= 1'b0;
      iocHeld  <= 1'b0;
    end else begin
      doorbell <= strobes.latchCmd;
      irqPulse <= strobes.captureDone && iocHeld;
      if (strobes.latchCmd) begin
        state   <= ST_BUSY;
        iocHeld <= iocReq;
      end else if (strobes.captureDone) begin
        state <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/ipc_mailbox_dp.sv
module ipc_mailbox_dp
  import ipc_mailbox_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BUF_WORDS   = 4,
  parameter int CMD_OFFS    = 'h00,
  parameter int STAT_OFFS   = 'h04,
  parameter int WBUF_BASE   = 'h80,
  parameter int RBUF_BASE   = 'h90,
  localparam int IDX_W      = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              hostByte,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              busy,
  input  mbStrobes_t        strobes,
  output logic              cmdWrite,
  output logic              ovrFlag,
  output logic [7:0]        ctlCmd,
  output logic [3:0]        ctlSubId,
  output logic [7:0]        ctlSize,
  input  logic [IDX_W-1:0]  ctlWbufIdx,
  output logic [DATA_W-1:0] ctlWbufData,
  input  logic              ctlRbufWe,
  input  logic [IDX_W-1:0]  ctlRbufIdx,
  input  logic [DATA_W-1:0] ctlRbufData,
  input  logic              ctlErr,
  input  logic [7:0]        ctlErrCode,
  input  logic [7:0]        ctlInitId
);

  localparam logic [ADDR_W-1:0] WB_LO = ADDR_W'(WBUF_BASE);
  localparam logic [ADDR_W-1:0] WB_HI = ADDR_W'(WBUF_BASE + 4 * BUF_WORDS);
  localparam logic [ADDR_W-1:0] RB_LO = ADDR_W'(RBUF_BASE);
  localparam logic [ADDR_W-1:0] RB_HI = ADDR_W'(RBUF_BASE + 4 * BUF_WORDS);
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_OFFS);
  localparam logic [ADDR_W-1:0] STA_A = ADDR_W'(STAT_OFFS);

  logic [DATA_W-1:0] wbuf [BUF_WORDS];
  logic [DATA_W-1:0] rbuf [BUF_WORDS];

  logic              inWbuf, inRbuf, isStat;
  logic [ADDR_W-1:0] wOff, rOff;
  logic [IDX_W-1:0]  wIdx, rIdx;
  logic              errFlag;
  logic [7:0]        errCode, initId;
  logic [DATA_W-1:0] statusWord, wordSel, rdNext;

  // Address decode, word-aligned
  assign cmdWrite = hostWr && (hostAddr[ADDR_W-1:2] == CMD_A[ADDR_W-1:2]);
  assign isStat   = (hostAddr[ADDR_W-1:2] == STA_A[ADDR_W-1:2]);
  assign inWbuf   = (hostAddr >= WB_LO) && (hostAddr < WB_HI);
  assign inRbuf   = (hostAddr >= RB_LO) && (hostAddr < RB_HI);
  assign wOff     = hostAddr - WB_LO;
  assign rOff     = hostAddr - RB_LO;
  assign wIdx     = wOff[IDX_W+1:2];
  assign rIdx     = rOff[IDX_W+1:2];

  // Latched command fields and completion state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlCmd   <= '0;
      ctlSubId <= '0;
      ctlSize  <= '0;
      errFlag  <= 1'b0;
      errCode  <= '0;
      initId   <= '0;
      ovrFlag  <= 1'b0;
    end else begin
      if (strobes.latchCmd) begin
        ctlCmd   <= hostWdata[7:0];
        ctlSubId <= hostWdata[15:12];
        ctlSize  <= hostWdata[23:16];
      end
      if (strobes.captureDone) begin
        errFlag <= ctlErr;
        errCode <= ctlErrCode;
        initId  <= ctlInitId;
      end
      if (strobes.setOverrun) ovrFlag <= 1'b1;
    end
  end

  // Payload and response storage
  for (genvar g = 0; g < BUF_WORDS; g++) begin : g_buf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wbuf[g] <= '0;
      else if (hostWr && inWbuf && (wIdx == IDX_W'(g))) wbuf[g] <= hostWdata;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rbuf[g] <= '0;
      else if (ctlRbufWe && (ctlRbufIdx == IDX_W'(g))) rbuf[g] <= ctlRbufData;
    end
  end

  assign ctlWbufData = wbuf[ctlWbufIdx];

  // Host read path
  assign statusWord = {8'h00, errCode, initId, ctlSubId, 1'b0, ovrFlag, errFlag, busy};

  always_comb begin
    if (isStat)      wordSel = statusWord;
    else if (inRbuf) wordSel = rbuf[rIdx];
    else             wordSel = '0;
    if (hostByte) rdNext = {24'h0, 8'(wordSel >> {hostAddr[1:0], 3'b000})};
    else          rdNext = wordSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       hostRdata <= '0;
    else if (hostRd) hostRdata <= rdNext;
  end

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mailbox_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUF_WORDS = 4,
  localparam int IDX_W    = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  input  logic              hostByte,
  output logic [31:0]       hostRdata,
  output logic              hostIrq,
  output logic              ctlDoorbell,
  output logic [7:0]        ctlCmd,
  output logic              ctlIoc,
  output logic [3:0]        ctlSubId,
  output logic [7:0]        ctlSize,
  input  logic [IDX_W-1:0]  ctlWbufIdx,
  output logic [31:0]       ctlWbufData,
  input  logic              ctlRbufWe,
  input  logic [IDX_W-1:0]  ctlRbufIdx,
  input  logic [31:0]       ctlRbufData,
  input  logic              ctlDone,
  input  logic              ctlErr,
  input  logic [7:0]        ctlErrCode,
  input  logic [7:0]        ctlInitId
);

  mbStrobes_t strobes;
  logic       busy;
  logic       cmdWrite;
  logic       ovrFlag;

  ipc_mailbox_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrite (cmdWrite),
    .iocReq   (hostWdata[8]),
    .ctlDone  (ctlDone),
    .busy     (busy),
    .doorbell (ctlDoorbell),
    .irqPulse (hostIrq),
    .iocHeld  (ctlIoc),
    .strobes  (strobes)
  );

  ipc_mailbox_dp #(
    .ADDR_W    (ADDR_W),
    .BUF_WORDS (BUF_WORDS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .hostWr      (hostWr),
    .hostRd      (hostRd),
    .hostAddr    (hostAddr),
    .hostWdata   (hostWdata),
    .hostByte    (hostByte),
    .hostRdata   (hostRdata),
    .busy        (busy),
    .strobes     (strobes),
    .cmdWrite    (cmdWrite),
    .ovrFlag     (ovrFlag),
    .ctlCmd      (ctlCmd),
    .ctlSubId    (ctlSubId),
    .ctlSize     (ctlSize),
    .ctlWbufIdx  (ctlWbufIdx),
    .ctlWbufData (ctlWbufData),
    .ctlRbufWe   (ctlRbufWe),
    .ctlRbufIdx  (ctlRbufIdx),
    .ctlRbufData (ctlRbufData),
    .ctlErr      (ctlErr),
    .ctlErrCode  (ctlErrCode),
    .ctlInitId   (ctlInitId)
  );

endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWr,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              busy,
  input logic              ovrFlag,
  input logic              doorbell,
  input logic              hostIrq,
  input logic              ctlDone,
  input logic [7:0]        ctlCmd
);

  logic cmdHit;
  assign cmdHit = hostWr && (hostAddr == '0);

  p_launch_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cmdHit && !busy) |=> (busy && doorbell));

  p_doorbell_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    doorbell |=> !doorbell);

  p_done_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctlDone) |=> !busy);

  p_busy_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctlDone) |=> busy);

  p_irq_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> $past(busy && ctlDone));

  p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |=> !hostIrq);

  p_overrun_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdHit && busy) |=> (ovrFlag && $stable(ctlCmd) && !doorbell));

  p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    ovrFlag |=> ovrFlag);

endmodule

bind ipc_mailbox ipc_mailbox_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostWr   (hostWr),
  .hostAddr (hostAddr),
  .busy     (busy),
  .ovrFlag  (ovrFlag),
  .doorbell (ctlDoorbell),
  .hostIrq  (hostIrq),
  .ctlDone  (ctlDone),
  .ctlCmd   (ctlCmd)
);

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0, hostRd = 1'b0, hostByte = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostIrq, ctlDoorbell, ctlIoc;
  logic [7:0]  ctlCmd, ctlSize;
  logic [3:0]  ctlSubId;
  logic [1:0]  ctlWbufIdx = '0, ctlRbufIdx = '0;
  logic [31:0] ctlWbufData;
  logic        ctlRbufWe = 1'b0;
  logic [31:0] ctlRbufData = '0;
  logic        ctlDone = 1'b0, ctlErr = 1'b0;
  logic [7:0]  ctlErrCode = '0, ctlInitId = '0;

  always #10 clk = ~clk;

  ipc_mailbox u_dut (.*);

  int nVec = 0;
  int nBad = 0;

  // Reference model state
  logic        mBusy = 0, mErr = 0, mOvr = 0, mIoc = 0;
  logic [3:0]  mSub = 0;
  logic [7:0]  mInit = 0, mCode = 0, mCmd = 0, mSize = 0;
  logic [31:0] mW [4];
  logic [31:0] mR [4];

  function automatic logic [31:0] expStatus();
    return {8'h00, mCode, mInit, mSub, 1'b0, mOvr, mErr, mBusy};
  endfunction

  function automatic logic [31:0] byteOf(logic [31:0] w, logic [1:0] b);
    return {24'h0, 8'(w >> (8 * b))};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic hostWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    hostWr = 1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 0;
  endtask

  task automatic hostRead(logic [7:0] a, logic byteMode, output logic [31:0] r);
    @(negedge clk);
    hostRd = 1; hostAddr = a; hostByte = byteMode;
    @(negedge clk);
    hostRd = 0; hostByte = 0;
    r = hostRdata;
  endtask

  task automatic modelCmd(logic [31:0] d);
    if (!mBusy) begin
      mBusy = 1; mCmd = d[7:0]; mIoc = d[8]; mSub = d[15:12]; mSize = d[23:16];
    end else begin
      mOvr = 1;
    end
  endtask

  task automatic ctlFinish(logic e, logic [7:0] code, logic [7:0] init);
    logic expIrq;
    expIrq = mBusy && mIoc;
    @(negedge clk);
    ctlDone = 1; ctlErr = e; ctlErrCode = code; ctlInitId = init;
    @(negedge clk);
    ctlDone = 0;
    check("R4 irq after done", 32'(hostIrq), 32'(expIrq));
    if (mBusy) begin
      mBusy = 0; mErr = e; mCode = code; mInit = init;
    end
    @(negedge clk);
    check("R4 irq single cycle", 32'(hostIrq), 32'h0);
  endtask

  task automatic checkStatus(string tag);
    logic [31:0] r;
    hostRead(8'h04, 1'b0, r);
    check(tag, r, expStatus());
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL R10 watchdog got=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic [31:0] r, d, hold;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 4; i++) begin mW[i] = 0; mR[i] = 0; end

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R10 irq at reset", 32'(hostIrq), 0);
    check("R10 doorbell at reset", 32'(ctlDoorbell), 0);
    checkStatus("R10 status at reset");

    // R8: ignored writes and zero reads
    hostWrite(8'h04, 32'hFFFF_FFFF);
    checkStatus("R8 status write ignored");
    hostWrite(8'h90, 32'hDEAD_BEEF);
    hostRead(8'h90, 1'b0, r);
    check("R8 rbuf host write ignored", r, 32'h0);
    hostWrite(8'h84, 32'h1234_5678);
    mW[1] = 32'h1234_5678;
    hostRead(8'h84, 1'b0, r);
    check("R8 wbuf reads zero", r, 32'h0);
    hostRead(8'h00, 1'b0, r);
    check("R8 command reads zero", r, 32'h0);

    // R3: done while idle changes nothing
    ctlFinish(1'b1, 8'h5A, 8'h33);
    checkStatus("R3 idle done ignored");

    // Random rounds
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < 4; i++) begin
        d = $urandom;
        hostWrite(8'(8'h80 + 4 * i), d);
        mW[i] = d;
      end
      d = $urandom;
      hostWrite(8'h00, d);
      modelCmd(d);
      check("R1 doorbell pulse", 32'(ctlDoorbell), 1);
      check("R1 opcode", 32'(ctlCmd), 32'(mCmd));
      check("R1 ioc flag", 32'(ctlIoc), 32'(mIoc));
      check("R1 sub id", 32'(ctlSubId), 32'(mSub));
      check("R6 size from command", 32'(ctlSize), 32'(mSize));
      @(negedge clk);
      check("R1 doorbell ends", 32'(ctlDoorbell), 0);
      for (int i = 0; i < 4; i++) begin
        ctlWbufIdx = 2'(i);
        #1;
        check("R6 controller reads wbuf", ctlWbufData, mW[i]);
      end
      checkStatus("R2 status while busy");
      if ($urandom_range(2) == 0) begin
        hostWrite(8'h00, $urandom);
        mOvr = 1;
        check("R5 no doorbell on overrun", 32'(ctlDoorbell), 0);
        check("R5 opcode kept", 32'(ctlCmd), 32'(mCmd));
        check("R5 size kept", 32'(ctlSize), 32'(mSize));
        checkStatus("R5 overrun flag");
      end
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        d = $urandom;
        ctlRbufWe = 1; ctlRbufIdx = 2'(i); ctlRbufData = d;
        mR[i] = d;
      end
      @(negedge clk);
      ctlRbufWe = 0;
      ctlFinish(1'($urandom), 8'($urandom), 8'($urandom));
      checkStatus("R3 status after done");
      begin
        int k;
        logic [1:0] b;
        k = $urandom_range(3);
        b = 2'($urandom);
        hostRead(8'(8'h90 + 4 * k), 1'b0, r);
        check("R7 rbuf word read", r, mR[k]);
        hostRead(8'(8'h90 + 4 * k + b), 1'b1, r);
        check("R7 rbuf byte read", r, byteOf(mR[k], b));
        hold = r;
        @(negedge clk);
        hostAddr = 8'h04;
        @(negedge clk);
        check("R9 rdata holds without read", hostRdata, hold);
      end
    end

    // Same-cycle command write and done
    hostWrite(8'h00, 32'h0003_51A7);
    modelCmd(32'h0003_5103 | 32'h0000_00A4);
    @(negedge clk);
    hostWr = 1; hostAddr = 8'h00; hostWdata = 32'h0000_01FF;
    ctlDone = 1; ctlErr = 0; ctlErrCode = 8'h11; ctlInitId = 8'h22;
    @(negedge clk);
    hostWr = 0; ctlDone = 0;
    mOvr = 1;
    check("R5 same-cycle write no doorbell", 32'(ctlDoorbell), 0);
    check("R4 same-cycle irq", 32'(hostIrq), 32'(mIoc));
    mBusy = 0; mErr = 0; mCode = 8'h11; mInit = 8'h22;
    check("R5 same-cycle opcode kept", 32'(ctlCmd), 32'h0000_00A7);
    checkStatus("R3 same-cycle status");

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule